// File: doc/BRIEF.md
# Signed Halfword Load Decoder

This block inspects one instruction word and decides whether it is a load of a signed halfword whose address uses an immediate offset. It understands three layouts. The first is a fixed-length 32-bit word with a condition field. The other two are pairs of 16-bit halfwords, with the first halfword in the upper half of `insn`. The `isa_sel` input says which instruction set is active: 0 for the fixed-length word and 1 for the halfword pairs.

For a recognised word the decoder reports:
- the destination and base register indices;
- the zero-extended immediate;
- the pre-index, add and base-update control bits.

It also classifies the word in one of three ways. A word may redirect to a related instruction: the literal-address form, the unprivileged-access form or the hint space. It may be undefined. It may be unpredictable.

The fixed policy for unpredictable words is to raise the undefined flag as well. A redirect takes priority over both of those flags. All outputs are registered when `OUT_REG` is 1 (the default), which gives one cycle of latency.

Top module: `shld_decode`

## Requirements
- R1: With `isa_sel`=0, a word matches only when all of these hold: bits 31:28 are not 1111, bits 27:25 are 000, bit 22 is 1, bit 20 is 1 and bits 7:4 are 1111. On a match, `rn_idx` is bits 19:16 and `rt_idx` is bits 15:12. `imm` is the zero extension of bits 11:8 (upper nibble) joined to bits 3:0 (lower nibble).
- R2: For the fixed-length word, with P = bit 24, U = bit 23 and W = bit 21, the controls are `idx_en`=P, `add_en`=U and `wb_en`=(not P) or W.
- R3: With `isa_sel`=1, a word whose bits 31:20 are 1111_1001_1011 matches the first pair form. `rn_idx` is bits 19:16, `rt_idx` is bits 15:12 and `imm` is the zero extension of bits 11:0. The controls are fixed at `idx_en`=1, `add_en`=1 and `wb_en`=0.
- R4: With `isa_sel`=1, a word matches the second pair form when bits 31:20 are 1111_1001_0011 and bit 11 is 1. `rn_idx` is bits 19:16 and `rt_idx` is bits 15:12. P, U and W are bits 10, 9 and 8, and `imm` is the zero extension of bits 7:0. The controls are `idx_en`=P, `add_en`=U and `wb_en`=W. If bit 11 is 0 the word does not match.
- R5: In every form, a base index of 15 gives `redir`=1 (literal form).
- R6: `redir`=2 (unprivileged form) in two cases: the fixed-length word with P=0 and W=1, and the second pair form with P,U,W = 1,1,0.
- R7: `redir`=3 (hint space) in two cases: the first pair form with a destination index of 15, and the second pair form with a destination index of 15 and P,U,W = 1,0,0.
- R8: The second pair form with P=0 and W=0 raises `undef_flag`, with `unpred_flag` low.
- R9: `unpred_flag` and `undef_flag` are both raised in two cases. The fixed-length word is unpredictable when the destination index is 15, or when `wb_en` is set and the base index equals the destination index. The second pair form is unpredictable when the destination index is 15 with W=1, or when `wb_en` is set and the two indices are equal.
- R10: Redirect has priority. When `redir` is nonzero, `undef_flag`, `unpred_flag` and `dec_ok` are low. `dec_ok` is high only for a matched word with no redirect and no undefined flag.
- R11: A word that matches no pattern of the selected set gives `no_match`=1 with every other output zero. Patterns of the unselected set are never matched.
- R12: While `rst_n` is low the outputs hold the reset state: `no_match`=1 and every other output zero. With `OUT_REG`=1, a decode result appears after the next rising clock edge and holds until the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| isa_sel | input | 1 | 0: fixed-length word set, 1: halfword-pair set |
| insn | input | 32 | Instruction word; first halfword in bits 31:16 for pair forms |
| dec_ok | output | 1 | Clean decode: matched, no redirect, not undefined |
| no_match | output | 1 | Word is not this instruction in the selected set |
| redir | output | 2 | 0 none, 1 literal form, 2 unprivileged form, 3 hint space |
| undef_flag | output | 1 | Undefined encoding (also raised for unpredictable) |
| unpred_flag | output | 1 | Unpredictable encoding |
| rt_idx | output | 4 | Destination register index |
| rn_idx | output | 4 | Base register index |
| imm | output | IMM_W | Zero-extended immediate offset |
| idx_en | output | 1 | Offset applied before the access |
| add_en | output | 1 | Offset is added (else subtracted) |
| wb_en | output | 1 | Base register is updated |

## Verification
The assertions assume that `isa_sel` and `insn` are known values at every rising edge once reset is released. The registered flag checks also rely on the output register. The stimulus meets both conditions: it drives only fully defined words at falling edges, and it gives every random word a defined selector. Random words are shaped around the three templates. Base and destination indices are drawn from a small set that includes 15 and equal pairs, so the overlap, redirect and priority paths are reached often and do not depend on chance.

// File: rtl/shld_pkg.sv
package shld_pkg;
   typedef enum logic [1:0] {
      RD_NONE   = 2'd0,
      RD_LIT    = 2'd1,
      RD_UNPRIV = 2'd2,
      RD_HINT   = 2'd3
   } redir_e;

   localparam int REG_W = 4;
   localparam int RAW_IMM_W = 12;
   localparam logic [REG_W-1:0] REG_TOP = 4'hF;

   typedef struct packed {
      logic                 hit;
      logic [REG_W-1:0]     rt;
      logic [REG_W-1:0]     rn;
      logic [RAW_IMM_W-1:0] imm;
      logic                 idx;
      logic                 add;
      logic                 wb;
      redir_e               rd;
      logic                 undef;
      logic                 unpred;
   } dec_t;
endpackage

// File: rtl/shld_dec_word.sv
module shld_dec_word
   import shld_pkg::*;
(
   input  logic [31:0] insn,
   output dec_t        d
);
   logic p_b, u_b, w_b, shape;

   assign p_b   = insn[24];
   assign u_b   = insn[23];
   assign w_b   = insn[21];
   assign shape = (insn[31:28] != 4'hF) && (insn[27:25] == 3'b000) &&
                  insn[22] && insn[20] && (insn[7:4] == 4'hF);

   always_comb begin
      d = '0;
      if (shape) begin
         d.hit = 1'b1;
         d.rn  = insn[19:16];
         d.rt  = insn[15:12];
         d.imm = {4'h0, insn[11:8], insn[3:0]};
         d.idx = p_b;
         d.add = u_b;
         d.wb  = !p_b || w_b;
         if (d.rn == REG_TOP)
            d.rd = RD_LIT;
         else if (!p_b && w_b)
            d.rd = RD_UNPRIV;
         else
            d.unpred = (d.rt == REG_TOP) || (d.wb && (d.rn == d.rt));
         d.undef = d.unpred;
      end
   end
endmodule

// File: rtl/shld_dec_pair_a.sv
module shld_dec_pair_a
   import shld_pkg::*;
(
   input  logic [31:0] insn,
   output dec_t        d
);
   localparam logic [11:0] OPC = 12'hF9B;

   always_comb begin
      d = '0;
      if (insn[31:20] == OPC) begin
         d.hit = 1'b1;
         d.rn  = insn[19:16];
         d.rt  = insn[15:12];
         d.imm = insn[11:0];
         d.idx = 1'b1;
         d.add = 1'b1;
         d.wb  = 1'b0;
         if (d.rn == REG_TOP)
            d.rd = RD_LIT;
         else if (d.rt == REG_TOP)
            d.rd = RD_HINT;
      end
   end
endmodule

// File: rtl/shld_dec_pair_b.sv
module shld_dec_pair_b
   import shld_pkg::*;
(
   input  logic [31:0] insn,
   output dec_t        d
);
   localparam logic [11:0] OPC = 12'hF93;
   logic [2:0] puw;

   assign puw = insn[10:8];

   always_comb begin
      d = '0;
      if ((insn[31:20] == OPC) && insn[11]) begin
         d.hit = 1'b1;
         d.rn  = insn[19:16];
         d.rt  = insn[15:12];
         d.imm = {4'h0, insn[7:0]};
         d.idx = puw[2];
         d.add = puw[1];
         d.wb  = puw[0];
         if (d.rn == REG_TOP)
            d.rd = RD_LIT;
         else if ((d.rt == REG_TOP) && (puw == 3'b100))
            d.rd = RD_HINT;
         else if (puw == 3'b110)
            d.rd = RD_UNPRIV;
         else if (!puw[2] && !puw[0])
            d.undef = 1'b1;
         else begin
            d.unpred = ((d.rt == REG_TOP) && puw[0]) ||
                       (d.wb && (d.rn == d.rt));
            d.undef  = d.unpred;
         end
      end
   end
endmodule

// File: rtl/shld_decode.sv
module shld_decode
   import shld_pkg::*;
#(
   parameter int IMM_W   = 32,
   parameter bit OUT_REG = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             isa_sel,
   input  logic [31:0]      insn,
   output logic             dec_ok,
   output logic             no_match,
   output logic [1:0]       redir,
   output logic             undef_flag,
   output logic             unpred_flag,
   output logic [REG_W-1:0] rt_idx,
   output logic [REG_W-1:0] rn_idx,
   output logic [IMM_W-1:0] imm,
   output logic             idx_en,
   output logic             add_en,
   output logic             wb_en
);
   generate
      if (IMM_W < RAW_IMM_W) begin : g_bad_imm_w
         $error("IMM_W must be at least 12");
      end
   endgenerate

   dec_t d_word, d_pa, d_pb, d_sel, q;

   shld_dec_word   u_word (.insn(insn), .d(d_word));
   shld_dec_pair_a u_pa   (.insn(insn), .d(d_pa));
   shld_dec_pair_b u_pb   (.insn(insn), .d(d_pb));

   always_comb begin
      if (!isa_sel)
         d_sel = d_word;
      else if (d_pa.hit)
         d_sel = d_pa;
      else if (d_pb.hit)
         d_sel = d_pb;
      else
         d_sel = '0;
   end

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= d_sel;
         end

         // R3
         pair_a_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(isa_sel && (insn[31:20] == 12'hF9B)) |->
               (idx_en && add_en && !wb_en && !no_match));

         // R12
         hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $stable(insn) && $stable(isa_sel) && $past(rst_n) |=> $stable(rt_idx) && $stable(imm));
      end else begin : g_comb
         assign q = d_sel;
      end
   endgenerate

   assign no_match    = !q.hit;
   assign dec_ok      = q.hit && (q.rd == RD_NONE) && !q.undef;
   assign redir       = q.rd;
   assign undef_flag  = q.undef;
   assign unpred_flag = q.unpred;
   assign rt_idx      = q.rt;
   assign rn_idx      = q.rn;
   assign imm         = IMM_W'(q.imm);
   assign idx_en      = q.idx;
   assign add_en      = q.add;
   assign wb_en       = q.wb;

   // R10
   redir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (redir != 2'd0) |-> (!undef_flag && !unpred_flag && !dec_ok));

   // R9
   unpred_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unpred_flag |-> undef_flag);

   // R11
   nomatch_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      no_match |-> (redir == 2'd0 && !undef_flag && !unpred_flag && !dec_ok &&
                    imm == '0 && !idx_en && !add_en && !wb_en &&
                    rt_idx == '0 && rn_idx == '0));

   // R5
   lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!no_match && rn_idx == REG_TOP) |-> (redir == 2'd1));

   // R10
   ok_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({dec_ok, no_match, undef_flag || (redir != 2'd0)}) == 1);
endmodule

// File: tb/tb_shld_decode.sv
`timescale 1ns/1ps
module tb_shld_decode;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic isa_sel = 1'b0;
   logic [31:0] insn = 32'h0;
   logic dec_ok, no_match, undef_flag, unpred_flag, idx_en, add_en, wb_en;
   logic [1:0] redir;
   logic [3:0] rt_idx, rn_idx;
   logic [31:0] imm;
   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   shld_decode dut (
      .clk(clk), .rst_n(rst_n), .isa_sel(isa_sel), .insn(insn),
      .dec_ok(dec_ok), .no_match(no_match), .redir(redir),
      .undef_flag(undef_flag), .unpred_flag(unpred_flag),
      .rt_idx(rt_idx), .rn_idx(rn_idx), .imm(imm),
      .idx_en(idx_en), .add_en(add_en), .wb_en(wb_en)
   );

   function automatic logic [48:0] outs();
      return {dec_ok, no_match, redir, undef_flag, unpred_flag,
              rt_idx, rn_idx, imm, idx_en, add_en, wb_en};
   endfunction

   function automatic logic [48:0] model(input logic s, input logic [31:0] i);
      logic nm, ud, up, ix, ad, wb, ok;
      logic [1:0] rd;
      logic [3:0] t, n;
      logic [31:0] im;
      logic [2:0] puw;
      nm = 1'b1; ud = 1'b0; up = 1'b0; ix = 1'b0; ad = 1'b0; wb = 1'b0;
      rd = 2'd0; im = 32'h0;
      n = i[19:16]; t = i[15:12]; puw = i[10:8];
      if (!s) begin
         if (i[31:28] != 4'hF && i[27:25] == 3'b0 && i[22] && i[20] && i[7:4] == 4'hF) begin
            nm = 1'b0; ix = i[24]; ad = i[23]; wb = !i[24] || i[21];
            im = {24'h0, i[11:8], i[3:0]};
            if (n == 4'hF) rd = 2'd1;
            else if (!i[24] && i[21]) rd = 2'd2;
            else if (t == 4'hF || (wb && n == t)) begin up = 1'b1; ud = 1'b1; end
         end
      end else if (i[31:20] == 12'hF9B) begin
         nm = 1'b0; ix = 1'b1; ad = 1'b1; im = {20'h0, i[11:0]};
         if (n == 4'hF) rd = 2'd1;
         else if (t == 4'hF) rd = 2'd3;
      end else if (i[31:20] == 12'hF93 && i[11]) begin
         nm = 1'b0; ix = puw[2]; ad = puw[1]; wb = puw[0]; im = {24'h0, i[7:0]};
         if (n == 4'hF) rd = 2'd1;
         else if (t == 4'hF && puw == 3'b100) rd = 2'd3;
         else if (puw == 3'b110) rd = 2'd2;
         else if (puw[2:1] == 2'b00 && !puw[0]) ud = 1'b1;
         else if (!puw[2] && !puw[0]) ud = 1'b1;
         else if ((t == 4'hF && puw[0]) || (wb && n == t)) begin up = 1'b1; ud = 1'b1; end
      end
      if (nm) begin t = 4'h0; n = 4'h0; end
      ok = !nm && rd == 2'd0 && !ud;
      return {ok, nm, rd, ud, up, t, n, im, ix, ad, wb};
   endfunction

   task automatic compare(input string tag, input logic [48:0] e);
      logic [48:0] a;
      a = outs();
      nchk++;
      if (a !== e) begin
         nerr++;
         $display("FAIL %s sel=%0b insn=%h actual=%h expected=%h", tag, isa_sel, insn, a, e);
      end
   endtask

   task automatic run(input string tag, input logic s, input logic [31:0] i);
      @(negedge clk);
      isa_sel = s;
      insn = i;
      @(negedge clk);
      compare(tag, model(s, i));
   endtask

   function automatic logic [3:0] pick_reg();
      int unsigned r;
      r = $urandom % 4;
      return (r == 0) ? 4'hF : (r == 1) ? 4'h2 : (r == 2) ? 4'h3 : 4'($urandom);
   endfunction

   initial begin
      logic [48:0] prev;
      void'($urandom(32'd20240611));
      #1;
      // R12 reset state
      compare("R12", {1'b0, 1'b1, 47'h0});
      repeat (3) @(negedge clk);
      compare("R12", {1'b0, 1'b1, 47'h0});
      rst_n = 1'b1;

      run("R1", 1'b0, 32'hE1D235FA);
      run("R2", 1'b0, 32'hE05235FA);
      run("R6", 1'b0, 32'hE07235FA);
      run("R5", 1'b0, 32'hE1DF35FA);
      run("R9", 1'b0, 32'hE1D2F5FA);
      run("R9", 1'b0, 32'hE05225FA);
      run("R11", 1'b0, 32'hF1D235FA);
      run("R11", 1'b0, 32'hE1D235EA);
      run("R3", 1'b1, 32'hF9B23123);
      run("R7", 1'b1, 32'hF9B2F123);
      run("R5", 1'b1, 32'hF9BF3123);
      run("R4", 1'b1, 32'hF9323D12);
      run("R6", 1'b1, 32'hF9323E12);
      run("R7", 1'b1, 32'hF932FC12);
      run("R8", 1'b1, 32'hF9323A12);
      run("R9", 1'b1, 32'hF9333B12);
      run("R9", 1'b1, 32'hF932FF12);
      run("R4", 1'b1, 32'hF9323512);
      run("R10", 1'b1, 32'hF93F3A12);
      run("R10", 1'b0, 32'hE07F35FA);
      run("R11", 1'b1, 32'hE1D235FA);
      run("R11", 1'b0, 32'hF9B23123);

      // R12 latency: output unchanged before the next rising edge
      prev = outs();
      @(negedge clk);
      isa_sel = 1'b1;
      insn = 32'hF9B45678;
      #1;
      compare("R12", prev);
      @(negedge clk);
      compare("R12", model(1'b1, 32'hF9B45678));

      for (int k = 0; k < 400; k++) begin
         logic [31:0] w;
         int unsigned kind;
         w = $urandom;
         kind = $urandom % 4;
         w[19:16] = pick_reg();
         w[15:12] = pick_reg();
         case (kind)
            0: begin
               w[27:25] = 3'b000; w[22] = 1'b1; w[20] = 1'b1; w[7:4] = 4'hF;
               if (w[31:28] == 4'hF && ($urandom % 2) == 0) w[31:28] = 4'hE;
               run("R2", 1'b0, w);
            end
            1: begin
               w[31:20] = 12'hF9B;
               run("R3", 1'b1, w);
            end
            2: begin
               w[31:20] = 12'hF93;
               if (($urandom % 4) != 0) w[11] = 1'b1;
               run("R4", 1'b1, w);
            end
            default: run("R11", 1'($urandom), w);
         endcase
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL R12 watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end
endmodule